// File: doc/BRIEF.md
# Barrel Shifter With Carry Out

This block is a purely combinational 32-bit shifter for an integer datapath. A 2-bit operation code picks a logical left shift, a logical right shift or an arithmetic right shift, and a 6-bit count sets the distance. Besides the shifted word, the block returns a carry that holds the last bit pushed off the end of the word, and an extend flag that copies that carry. The carry held by the flag register before the operation is fed back in, so that a shift of zero leaves it unchanged.

Counts from 32 up to 63 are legal and follow fixed rules, and code 11 passes the operand through untouched. All three shift kinds run through one right-shifting barrel. A left shift reverses the bits before the barrel and after it.

Top module: `shf_barrel_top`

## Requirements
- R1: The count is an unsigned 6-bit value. Every value from 0 to 63 gives a defined result, so the distance is the count modulo 64.
- R2: A count of 0 makes data_out equal data_in and carry_out equal carry_in, whatever op_sel holds.
- R3: op_sel 00 selects a logical left shift, 01 a logical right shift with zero fill, and 10 an arithmetic right shift that copies bit 31. For counts 1 to 31 the result is the operand shifted by that distance.
- R4: For counts n from 1 to 31, carry_out is bit (32-n) of data_in for a left shift and bit (n-1) for either right shift.
- R5: A logical shift by exactly 32 gives a zero result. carry_out is data_in bit 0 for a left shift and bit 31 for a right shift.
- R6: A logical shift by 33 to 63 gives a zero result and carry_out 0.
- R7: An arithmetic right shift by 32 to 63 fills all 32 result bits with data_in bit 31, and carry_out equals data_in bit 31.
- R8: extend_out always equals carry_out.
- R9: op_sel 11 makes data_out equal data_in and carry_out equal carry_in for any count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 2 | Shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 pass |
| shift_cnt | input | 6 | Shift distance, 0 to 63 |
| data_in | input | 32 | Operand |
| carry_in | input | 1 | Carry flag from before the operation |
| data_out | output | 32 | Shifted result |
| carry_out | output | 1 | Last bit shifted out, or carry_in when nothing moves |
| extend_out | output | 1 | Copy of carry_out |

## Verification
The hardest cases are the three edges of the count range: 0, exactly 32 and just above 32. At these edges the carry comes from a different place, or a fixed value replaces it, and a random count rarely lands on them. The stimulus therefore sweeps every count from 0 to 63 for each operation code. It uses operands whose bit 0 and bit 31 differ from their neighbours, and drives carry_in both ways. A wrong carry at count 32 or 33 then changes a visible output.

// File: rtl/shf_pkg.sv
package shf_pkg;

   typedef enum logic [1:0] {
      SHF_LSL  = 2'b00,
      SHF_LSR  = 2'b01,
      SHF_ASR  = 2'b10,
      SHF_PASS = 2'b11
   } shf_op_e;

   // Count classes; exactly one is set for any count value.
   typedef struct packed {
      logic none;    // count is zero
      logic part;    // 1 .. WIDTH-1
      logic full;    // exactly WIDTH
      logic beyond;  // above WIDTH
   } shf_cls_t;

endpackage

// File: rtl/shf_count_class.sv
module shf_count_class
   import shf_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int CNT_W = 6
) (
   input  logic [CNT_W-1:0] amt,
   output shf_cls_t         cls
);

   localparam logic [CNT_W-1:0] FULL_AMT = CNT_W'(WIDTH);

   always_comb begin
      cls.none   = (amt == '0);
      cls.full   = (amt == FULL_AMT);
      cls.beyond = (amt > FULL_AMT);
      cls.part   = !cls.none && (amt < FULL_AMT);
   end

   always_comb begin
      p_class_onehot_r1: assert ($countones(cls) == 1)
         else $error("count class not one-hot for %0d", amt);
   end

endmodule

// File: rtl/shf_right_barrel.sv
module shf_right_barrel #(
   parameter int WIDTH = 32,
   parameter int CNT_W = 6
) (
   input  logic [WIDTH-1:0] din,
   input  logic [CNT_W-1:0] amt,
   input  logic             fill,
   output logic [WIDTH-1:0] dout
);

   localparam int LOG = $clog2(WIDTH);

   logic [WIDTH-1:0] stage [0:LOG];
   assign stage[0] = din;

   // One stage per count bit below the saturation bit.
   for (genvar s = 0; s < LOG; s++) begin : g_stage
      localparam int DIST = 1 << s;
      always_comb begin
         if (amt[s])
            stage[s+1] = {{DIST{fill}}, stage[s][WIDTH-1:DIST]};
         else
            stage[s+1] = stage[s];
      end
   end

   // Upper count bits: distance reaches the whole word.
   logic sat;
   assign sat  = |amt[CNT_W-1:LOG];
   assign dout = sat ? {WIDTH{fill}} : stage[LOG];

   always_comb begin
      if (amt == '0)
         p_barrel_idle_r2: assert (dout == din)
            else $error("barrel moved data at zero distance");
   end

endmodule

// File: rtl/shf_carry_sel.sv
module shf_carry_sel
   import shf_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int CNT_W = 6
) (
   input  logic [WIDTH-1:0] din,    // operand in right-shift orientation
   input  logic [CNT_W-1:0] amt,
   input  shf_cls_t         cls,
   input  logic             arith,
   input  logic             cin,
   output logic             cout
);

   localparam int LOG = $clog2(WIDTH);

   // amt-1 taken modulo WIDTH: amt == WIDTH wraps to the top bit.
   logic [LOG-1:0] last_idx;
   assign last_idx = LOG'(amt[LOG-1:0] - 1'b1);

   always_comb begin
      if (cls.none)
         cout = cin;
      else if (cls.beyond)
         cout = arith ? din[WIDTH-1] : 1'b0;
      else
         cout = din[last_idx];
   end

endmodule

// File: rtl/shf_barrel_top.sv
module shf_barrel_top
   import shf_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int CNT_W = 6
) (
   input  logic [1:0]       op_sel,
   input  logic [CNT_W-1:0] shift_cnt,
   input  logic [WIDTH-1:0] data_in,
   input  logic             carry_in,
   output logic [WIDTH-1:0] data_out,
   output logic             carry_out,
   output logic             extend_out
);

   localparam int LOG = $clog2(WIDTH);

   if ((1 << LOG) != WIDTH) begin : g_bad_width
      $error("WIDTH must be a power of two");
   end
   if (CNT_W != LOG + 1) begin : g_bad_cnt
      $error("CNT_W must be log2(WIDTH)+1");
   end

   shf_op_e  op;
   shf_cls_t cls;
   logic     go_left, is_arith, idle;
   logic [WIDTH-1:0] oriented, shifted, unoriented, rev_in, rev_out;
   logic     fill, carry_sh;

   assign op       = shf_op_e'(op_sel);
   assign go_left  = (op == SHF_LSL);
   assign is_arith = (op == SHF_ASR);

   shf_count_class #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_cls (
      .amt (shift_cnt),
      .cls (cls)
   );

   // Bit reversal lets one right barrel serve left shifts too.
   for (genvar i = 0; i < WIDTH; i++) begin : g_rev
      assign rev_in[i]  = data_in[WIDTH-1-i];
      assign rev_out[i] = shifted[WIDTH-1-i];
   end

   assign oriented = go_left ? rev_in : data_in;
   assign fill     = is_arith & data_in[WIDTH-1];

   shf_right_barrel #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_bar (
      .din  (oriented),
      .amt  (shift_cnt),
      .fill (fill),
      .dout (shifted)
   );

   shf_carry_sel #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_car (
      .din   (oriented),
      .amt   (shift_cnt),
      .cls   (cls),
      .arith (is_arith),
      .cin   (carry_in),
      .cout  (carry_sh)
   );

   assign unoriented = go_left ? rev_out : shifted;
   assign idle       = (op == SHF_PASS) || cls.none;

   always_comb begin
      if (idle) begin
         data_out  = data_in;
         carry_out = carry_in;
      end else begin
         data_out  = unoriented;
         carry_out = carry_sh;
      end
   end
   assign extend_out = carry_out;

   always_comb begin
      if (op_sel == 2'b11 || shift_cnt == '0)
         p_pass_keep_r9: assert (data_out == data_in && carry_out == carry_in)
            else $error("idle operation altered data or carry");
      if ((op_sel == 2'b00 || op_sel == 2'b01) && shift_cnt > CNT_W'(WIDTH))
         p_logic_beyond_r6: assert (data_out == '0 && !carry_out)
            else $error("logical shift beyond width not cleared");
      if (op_sel == 2'b10 && shift_cnt >= CNT_W'(WIDTH))
         p_asr_sat_r7: assert (($countones(data_out) == 0 || $countones(data_out) == WIDTH)
                               && data_out[0] == data_in[WIDTH-1]
                               && carry_out == data_in[WIDTH-1])
            else $error("arithmetic saturation wrong");
      if (op_sel == 2'b00 && shift_cnt == CNT_W'(WIDTH))
         p_lsl_full_r5: assert (data_out == '0 && carry_out == data_in[0])
            else $error("left shift by width wrong");
   end

endmodule

// File: tb/shf_barrel_top_test.sv
module shf_barrel_top_test;

   localparam int W = 32;

   logic clk = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic [1:0]   op_sel;
   logic [5:0]   shift_cnt;
   logic [W-1:0] data_in, data_out;
   logic         carry_in, carry_out, extend_out;

   shf_barrel_top uut (
      .op_sel     (op_sel),
      .shift_cnt  (shift_cnt),
      .data_in    (data_in),
      .carry_in   (carry_in),
      .data_out   (data_out),
      .carry_out  (carry_out),
      .extend_out (extend_out)
   );

   typedef struct {
      logic [1:0]   op;
      int           n;
      logic [W-1:0] val;
      logic [W-1:0] exp_d;
      logic         exp_c;
      string        req;
   } item_t;

   item_t q[$];
   int total = 0;
   int bad   = 0;
   bit done  = 0;

   function automatic string tag_of(logic [1:0] op, int n);
      if (op == 2'b11) return "R9";
      if (n == 0)      return "R2";
      if (op == 2'b10 && n >= 32) return "R7";
      if (n == 32)     return "R5";
      if (n > 32)      return "R6";
      return "R3/R4";
   endfunction

   task automatic drive(logic [1:0] op, int n, logic [W-1:0] val, logic cin);
      item_t it;
      logic [W-1:0] d;
      logic c;
      if (op == 2'b11 || n == 0) begin
         d = val; c = cin;
      end else if (op == 2'b00) begin
         if (n < 32)       begin d = val << n; c = val[32-n]; end
         else if (n == 32) begin d = '0;       c = val[0];    end
         else              begin d = '0;       c = 1'b0;      end
      end else if (op == 2'b01) begin
         if (n < 32)       begin d = val >> n; c = val[n-1];  end
         else if (n == 32) begin d = '0;       c = val[31];   end
         else              begin d = '0;       c = 1'b0;      end
      end else begin
         if (n < 32) begin d = W'($signed(val) >>> n); c = val[n-1]; end
         else        begin d = {W{val[31]}};            c = val[31];  end
      end
      @(posedge clk); #1;
      op_sel = op; shift_cnt = 6'(n); data_in = val; carry_in = cin;
      it.op = op; it.n = n; it.val = val; it.exp_d = d; it.exp_c = c;
      it.req = tag_of(op, n);
      q.push_back(it);
   endtask

   // Monitor: compares at the falling edge, mid-cycle.
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            total++;
            if (data_out !== it.exp_d || carry_out !== it.exp_c) begin
               bad++;
               $display("FAIL %s op=%b n=%0d val=%h: got d=%h c=%b exp d=%h c=%b",
                        it.req, it.op, it.n, it.val, data_out, carry_out, it.exp_d, it.exp_c);
            end
            total++;
            if (extend_out !== carry_out) begin   // R8
               bad++;
               $display("FAIL R8 op=%b n=%0d: extend=%b exp %b",
                        it.op, it.n, extend_out, carry_out);
            end
         end
      end
   end

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      logic [W-1:0] pats [4];
      pats[0] = 32'h8000_0001;
      pats[1] = 32'h7FFF_FFFE;
      pats[2] = 32'hC35A_96F1;
      pats[3] = 32'h1234_5678;
      op_sel = 2'b00; shift_cnt = '0; data_in = '0; carry_in = 1'b0;
      // Quiet start: all zero inputs give zero outputs (R2)
      drive(2'b00, 0, '0, 1'b0);
      // R2 zero count keeps carry in both polarities
      drive(2'b01, 0, 32'hDEAD_BEEF, 1'b1);
      drive(2'b10, 0, 32'h8000_0000, 1'b0);
      // R1/R3/R4/R5/R6/R7 full count sweep per operation
      for (int op = 0; op < 3; op++)
         for (int p = 0; p < 4; p++)
            for (int n = 0; n < 64; n++)
               drive(2'(op), n, pats[p], 1'((n + p) & 1));
      // R9 pass code with every count
      for (int n = 0; n < 64; n++)
         drive(2'b11, n, pats[n % 4] ^ 32'(n), 1'(n & 1));
      wait (q.size() == 0);
      @(posedge clk);
      done = 1;
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog: run did not finish, got hung exp done");
         summary();
      end
   end

endmodule